// File: doc/BRIEF.md
# Cascadable Cyclic Redundancy Shift Engine

This block is a programmable Galois-form feedback shift register. It computes CRC and frame check remainders, checks received blocks, and produces syndromes for burst-error (Fire-type) decoding. The register is built from two 24-stage sections.

The mode selects how the sections are used:
- **Single:** only the low section is used, for generator degrees up to 24.
- **Cascaded:** both sections act as one 48-stage register, for degrees up to 48.

The generator is loaded while the block is idle. It is given as a tap mask and a degree.

A session has three steps:
1. A start pulse clears the sections in use.
2. The input phase takes one serial bit, MSB first, on every cycle with valid high.
3. A run command switches to the run phase. This phase performs a programmed number of further shifts with the data path gated off.

A one-cycle done pulse ends the session. The syndrome then stays on the output until the next session. A registered flag reports when every stage in use is zero. Software uses this flag for codeword checks and for the zero-detect step of burst decoding.

Top module: `crc_cascade_engine`

## Requirements
- R1: After reset the syndrome is all zero, the zero flag is 1, and busy and done are 0.
- R2: A start pulse is taken only while idle and only when mode bit 1 is set. With mode bit 1 clear, the block stays idle and the syndrome does not change.
- R3: An accepted start clears only the sections in use: the low section in single mode (mode 2'b10), both sections in cascaded mode (mode 2'b11). The block then enters the input phase.
- R4: Each shift works as follows, for a degree d:
  - The feedback bit is stage d-1 XOR the gated data bit.
  - Stage i takes stage i-1 XOR (tap i AND feedback).
  - Stage 0 takes tap 0 AND feedback.
  - Stages at or above d stay zero.
  - In the input phase, one shift happens per valid cycle, MSB first.
- R5: The data bit reaches the feedback only if the input-enable bit of the section holding stage d-1 is set. Bit 0 covers stages 0..23 and bit 1 covers stages 24..47. Otherwise the shift uses a data value of 0.
- R6: A run command in the input phase loads the run length. Exactly that many further shifts follow, with data forced to 0 whatever data and valid do.
- R7: After the last run shift, done is high for exactly one cycle. The block then returns to idle, and the syndrome holds its value.
- R8: In cascaded mode, stage 23 feeds stage 24 on every shift, so the two sections behave as one 48-stage register.
- R9: In single mode the upper section is frozen. It keeps its contents through the whole session, including the clear.
- R10: After every clear or shift, the zero flag is 1 exactly when all stages in use (24 or 48) are zero. While idle the flag holds its value.
- R11: A polynomial load (taps and degree) is taken only while idle and is ignored during a session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Bit 1: parity operation on. Bit 0: cascade both sections |
| poly_load_i | input | 1 | Load taps and degree (idle only) |
| poly_taps_i | input | 48 | Generator tap mask, bit i = coefficient of x^i |
| poly_degree_i | input | 6 | Generator degree, 1..48 |
| in_en_i | input | 2 | Per-section data input enable |
| start_i | input | 1 | Begin a session (clear and enter input phase) |
| data_i | input | 1 | Serial data bit |
| valid_i | input | 1 | Data bit valid in input phase |
| run_i | input | 1 | Leave input phase and start run phase |
| run_len_i | input | 16 | Number of run-phase shifts |
| syndrome_o | output | 48 | Register contents |
| zero_o | output | 1 | All stages in use are zero |
| busy_o | output | 1 | Session in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |

## Verification
The embedded properties are checked on every cycle:
- the upper section stays frozen during single-mode sessions;
- the zero flag agrees with the stages in use;
- stages above the degree stay clear;
- the polynomial holds steady during a session;
- done lasts a single cycle;
- the mode gates the start pulse;
- the run phase persists while shifts remain.

Only the bench scenarios can show that the remainder is arithmetically correct. They cover:
- a known CRC result;
- the stage-23 to stage-24 link in cascaded mode;
- gating of data by the input enables;
- the exact number of run shifts while data is being driven;
- a codeword that drives the syndrome to zero.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INPUT = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // stage idx lies below the generator degree
  function automatic logic below_degree(input int idx, input int deg);
    return idx < deg;
  endfunction

  // feedback stage index, with degree 0 treated as 1 and clamped to the active length
  function automatic int feedback_stage(input int deg, input int active_len);
    int d;
    d = (deg == 0) ? 1 : deg;
    if (d > active_len) d = active_len;
    return d - 1;
  endfunction

endpackage

// File: rtl/crc_section.sv
module crc_section #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         cin_i,
  input  logic         fb_i,
  input  logic [W-1:0] taps_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);

  always_comb begin
    if (clr_i)        nxt_o = '0;
    else if (shift_i) nxt_o = ({q_o[W-2:0], cin_i} ^ (taps_i & {W{fb_i}})) & mask_i;
    else              nxt_o = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt_o;
  end

endmodule

// File: rtl/crc_phase_seq.sv
module crc_phase_seq
  import crc_eng_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ok_i,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] run_len_i,
  input  logic             valid_i,
  output phase_e           phase_o,
  output logic             shift_o,
  output logic             clr_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_run;

  assign clr_o    = (phase_o == PH_IDLE) && start_i && mode_ok_i;
  assign last_run = (phase_o == PH_RUN) && (cnt_q == '0);
  assign shift_o  = ((phase_o == PH_INPUT) && valid_i) ||
                    ((phase_o == PH_RUN) && (cnt_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_run;
      unique case (phase_o)
        PH_IDLE:  if (clr_o) phase_o <= PH_INPUT;
        PH_INPUT: if (run_i) begin
                    phase_o <= PH_RUN;
                    cnt_q   <= run_len_i;
                  end
        PH_RUN:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                  else             phase_o <= PH_IDLE;
        default:  phase_o <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_START_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_IDLE && !mode_ok_i) |=> (phase_o == PH_IDLE)); // R2

  AST_RUN_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_RUN && cnt_q != '0) |=> (phase_o == PH_RUN)); // R6

endmodule

// File: rtl/crc_cascade_engine.sv
module crc_cascade_engine
  import crc_eng_pkg::*;
#(
  parameter int SEC_W = 24,
  parameter int NSEC  = 2,
  parameter int DEG_W = 6,
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode_i,
  input  logic                  poly_load_i,
  input  logic [SEC_W*NSEC-1:0] poly_taps_i,
  input  logic [DEG_W-1:0]      poly_degree_i,
  input  logic [NSEC-1:0]       in_en_i,
  input  logic                  start_i,
  input  logic                  data_i,
  input  logic                  valid_i,
  input  logic                  run_i,
  input  logic [CNT_W-1:0]      run_len_i,
  output logic [SEC_W*NSEC-1:0] syndrome_o,
  output logic                  zero_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam int TOT_W = SEC_W * NSEC;
  localparam int IDX_W = $clog2(TOT_W);

  phase_e             phase;
  logic               shift, clr;
  logic               cas_q, cas_now;
  logic [TOT_W-1:0]   taps_q, syn_q, syn_nxt, deg_mask, act_mask;
  logic [DEG_W-1:0]   deg_q;
  logic [IDX_W-1:0]   fb_idx;
  logic               din_gate, fb, zero_q;

  crc_phase_seq #(.CNT_W(CNT_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_ok_i (mode_i[1]),
    .start_i   (start_i),
    .run_i     (run_i),
    .run_len_i (run_len_i),
    .valid_i   (valid_i),
    .phase_o   (phase),
    .shift_o   (shift),
    .clr_o     (clr),
    .done_o    (done_o)
  );

  // cascade choice follows the mode pin while idle, then stays latched for the session
  assign cas_now = (phase == PH_IDLE) ? mode_i[0] : cas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_q  <= 1'b0;
      taps_q <= '0;
      deg_q  <= DEG_W'(1);
      zero_q <= 1'b1;
    end else begin
      if (clr) cas_q <= mode_i[0];
      if (poly_load_i && phase == PH_IDLE) begin
        taps_q <= poly_taps_i;
        deg_q  <= poly_degree_i;
      end
      if (clr || shift) zero_q <= ((syn_nxt & act_mask) == '0);
    end
  end

  always_comb begin
    for (int i = 0; i < TOT_W; i++) deg_mask[i] = below_degree(i, int'(deg_q));
    for (int s = 0; s < NSEC; s++)
      act_mask[s*SEC_W +: SEC_W] = (s == 0 || cas_now) ? '1 : '0;
  end

  assign fb_idx = IDX_W'(feedback_stage(int'(deg_q), cas_now ? TOT_W : SEC_W));

  always_comb begin
    din_gate = 1'b0;
    for (int s = 0; s < NSEC; s++)
      if (int'(fb_idx) / SEC_W == s) din_gate = in_en_i[s];
  end

  assign fb = syn_q[fb_idx] ^ (data_i & din_gate & (phase == PH_INPUT));

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    logic sec_en, cin;
    assign sec_en = (s == 0) || cas_now;
    if (s == 0) begin : g_head
      assign cin = 1'b0;
    end else begin : g_link
      assign cin = syn_q[s*SEC_W-1];
    end
    crc_section #(.W(SEC_W)) sec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr & sec_en),
      .shift_i (shift & sec_en),
      .cin_i   (cin),
      .fb_i    (fb),
      .taps_i  (taps_q[s*SEC_W +: SEC_W]),
      .mask_i  (deg_mask[s*SEC_W +: SEC_W]),
      .q_o     (syn_q[s*SEC_W +: SEC_W]),
      .nxt_o   (syn_nxt[s*SEC_W +: SEC_W])
    );
  end

  assign syndrome_o = syn_q;
  assign zero_o     = zero_q;
  assign busy_o     = (phase != PH_IDLE);

  AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !cas_q) |=> $stable(syn_q[TOT_W-1:SEC_W])); // R9

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (zero_q == ((syn_q & act_mask) == '0))); // R10

  AST_ABOVE_DEGREE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> ((syn_q & act_mask & ~deg_mask) == '0)); // R4

  AST_POLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> ($stable(taps_q) && $stable(deg_q))); // R11

endmodule

// File: tb/crc_cascade_engine_tb_top.sv
`timescale 1ns/1ps
module crc_cascade_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        poly_load_i = 1'b0;
  logic [47:0] poly_taps_i = '0;
  logic [5:0]  poly_degree_i = 6'd1;
  logic [1:0]  in_en_i = 2'b00;
  logic        start_i = 1'b0, data_i = 1'b0, valid_i = 1'b0, run_i = 1'b0;
  logic [15:0] run_len_i = '0;
  logic [47:0] syndrome_o;
  logic        zero_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  crc_cascade_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .poly_load_i(poly_load_i),
    .poly_taps_i(poly_taps_i), .poly_degree_i(poly_degree_i), .in_en_i(in_en_i),
    .start_i(start_i), .data_i(data_i), .valid_i(valid_i), .run_i(run_i),
    .run_len_i(run_len_i), .syndrome_o(syndrome_o), .zero_o(zero_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, errors = 0;

  typedef struct packed { logic [47:0] syn; logic zero; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // independent reference state
  logic [47:0] m_reg = '0, m_taps = '0;
  int          m_deg = 1;
  bit          m_cas = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic void m_shift(input bit din);
    logic [47:0] n;
    int w;
    bit f;
    w = m_cas ? 48 : 24;
    f = m_reg[m_deg-1] ^ din;
    n = m_reg;
    for (int i = w - 1; i >= 1; i--) n[i] = (i < m_deg) ? (m_reg[i-1] ^ (m_taps[i] & f)) : 1'b0;
    n[0] = m_taps[0] & f;
    m_reg = n;
  endfunction

  function automatic bit m_zero();
    return m_cas ? (m_reg == '0) : (m_reg[23:0] == '0);
  endfunction

  task automatic load_poly(input logic [47:0] taps, input int deg);
    @(negedge clk);
    poly_load_i = 1'b1; poly_taps_i = taps; poly_degree_i = 6'(deg);
    @(negedge clk);
    poly_load_i = 1'b0;
    m_taps = taps; m_deg = deg;
  endtask

  task automatic session(input string tag, input logic [1:0] mode, input logic [1:0] en,
                         input logic [127:0] msg, input int nb, input int rl,
                         input bit noise, input bit poke_poly);
    bit gate;
    @(negedge clk);
    mode_i = mode; in_en_i = en; start_i = 1'b1;
    m_cas = mode[0];
    if (m_cas) m_reg = '0; else m_reg[23:0] = '0;
    gate = en[(m_deg - 1) / 24];
    @(negedge clk);
    start_i = 1'b0;
    for (int k = nb - 1; k >= 0; k--) begin
      data_i = msg[k]; valid_i = 1'b1;
      m_shift(msg[k] & gate);
      if (poke_poly && k == nb / 2) begin
        poly_load_i = 1'b1; poly_taps_i = ~m_taps; poly_degree_i = 6'd5;
      end
      @(negedge clk);
      poly_load_i = 1'b0;
    end
    valid_i = 1'b0; data_i = 1'b0;
    run_i = 1'b1; run_len_i = 16'(rl);
    for (int k = 0; k < rl; k++) m_shift(1'b0);
    exp_q.push_back('{syn: m_reg, zero: m_zero()});
    tag_q.push_back(tag);
    @(negedge clk);
    run_i = 1'b0;
    while (exp_q.size() != 0) begin
      if (noise) begin valid_i = 1'b1; data_i = ~data_i; end
      @(negedge clk);
    end
    valid_i = 1'b0; data_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare results as the design produces them
  initial begin
    exp_t  e;
    string t;
    logic [47:0] held;
    forever begin
      @(negedge clk);
      if (done_o && exp_q.size() != 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, 64'(syndrome_o), 64'(e.syn), "syndrome");
        check(t, 64'(zero_o), 64'(e.zero), "zero flag");
        held = syndrome_o;
        @(negedge clk);
        check("R7", 64'(done_o), 64'd0, "done width");
        check("R7", 64'(syndrome_o), 64'(held), "syndrome hold");
        check("R7", 64'(busy_o), 64'd0, "idle after done");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] saved;
    logic [15:0] rem;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", 64'(syndrome_o), 64'd0, "reset syndrome");
    check("R1", 64'(zero_o), 64'd1, "reset zero");
    check("R1", 64'({busy_o, done_o}), 64'd0, "reset busy/done");

    // R2: start with parity bit clear is ignored
    saved = syndrome_o;
    mode_i = 2'b01; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check("R2", 64'(busy_o), 64'd0, "gated start busy");
    check("R2", 64'(syndrome_o), 64'(saved), "gated start syndrome");

    // R4: known 16-bit remainder of "123456789"
    load_poly(48'h1021, 16);
    session("R4", 2'b10, 2'b01, 128'h313233343536373839, 72, 0, 1'b0, 1'b0);
    check("R4", 64'(syndrome_o[15:0]), 64'h31C3, "known remainder");

    // R6: run phase with data toggling
    session("R6", 2'b10, 2'b01, 128'h12345678, 32, 16, 1'b1, 1'b0);

    // R10: codeword drives syndrome to zero
    session("R10", 2'b10, 2'b01, 128'h12345678, 32, 0, 1'b0, 1'b0);
    rem = syndrome_o[15:0];
    session("R10", 2'b10, 2'b01, {80'h0, 32'h12345678, rem}, 48, 0, 1'b0, 1'b0);
    check("R10", 64'({syndrome_o[15:0], zero_o}), 64'h1, "codeword zero");

    // R11: load during session ignored
    session("R11", 2'b10, 2'b01, 128'hA5C3_0F96, 32, 8, 1'b0, 1'b1);
    session("R11", 2'b10, 2'b01, 128'h0BEE, 16, 4, 1'b0, 1'b0);

    // R5: input enable clear gates data (single mode)
    session("R5", 2'b10, 2'b00, 128'hFFFF_1234, 32, 5, 1'b0, 1'b0);
    check("R5", 64'({syndrome_o[23:0], zero_o}), 64'h1, "gated data");

    // R8: cascaded 40-degree generator, feedback in upper section
    load_poly(48'h00A1_0300_4821, 40);
    session("R8", 2'b11, 2'b10, 128'hDEAD_BEEF_0123_4567, 64, 20, 1'b1, 1'b0);
    check("R8", 64'(syndrome_o[47:24] != 24'h0), 64'd1, "upper section used");

    // R9: single mode leaves upper section untouched
    saved = syndrome_o;
    load_poly(48'h1021, 16);
    session("R9", 2'b10, 2'b01, 128'h5A5A, 16, 3, 1'b0, 1'b0);
    check("R9", 64'(syndrome_o[47:24]), 64'(saved[47:24]), "upper frozen");

    // R3: cascaded start clears both sections; data gated by enable bit 1
    load_poly(48'h00A1_0300_4821, 40);
    session("R3", 2'b11, 2'b01, 128'hFACE_CAFE, 32, 6, 1'b0, 1'b0);
    check("R3", 64'({syndrome_o, zero_o}), 64'h1, "cascade clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule